// File: doc/BRIEF.md
# GPIO Port with Interrupt Detection

This block is a general-purpose I/O port with up to 32 pins and a simple word-addressed register interface. Software chooses a direction for each pin and drives output values through a data register. Three write-only alias addresses set, clear or toggle chosen output bits in a single write, so no read-modify-write sequence is needed. Pad levels pass through a two-flop synchronizer before anything reads them, and software can read the synchronized levels.

Each pin has its own event detector. A 2-bit code selects one of four trigger conditions: low level, high level, rising edge or falling edge. The codes for the lower sixteen pins are in one configuration register and the codes for the upper sixteen pins are in a second one. A per-pin edge-select bit makes the pin trigger on both edges and causes its code to be ignored. Detected events are latched in a sticky status register, which software clears by writing 1s to it. A mask register chooses which latched events drive the single registered interrupt output.

Top module: `gpio_irq_port`

## Requirements
- R1: Direction register (offset 0x04) bit n = 1 makes pin n an output and asserts `pad_oe[n]`. A 0 makes the pin an input and deasserts `pad_oe[n]`.
- R2: A write to the data register (offset 0x00) is stored. Reading offset 0x00 returns the stored values, and `pad_out` carries the same values.
- R3: Writing a mask to the set alias (0x84) ORs the mask into the data register and leaves the unmasked bits unchanged. The alias reads back as zero.
- R4: Writing a mask to the clear alias (0x88) forces the masked data bits to 0 and leaves the other bits unchanged. The alias reads back as zero.
- R5: Writing a mask to the toggle alias (0x8C) inverts the masked data bits and leaves the other bits unchanged. The alias reads back as zero.
- R6: The pad-status register (0x08) returns `pad_in` as seen through a two-flop synchronizer. A change becomes visible two rising clock edges after it is applied, and not after one.
- R7: Pin n's 2-bit trigger code is at bit position (n mod 16)*2. Pins 0 to 15 take it from config register A (0x0C) and pins 16 to 31 from config register B (0x10). The codes are 0 for low level, 1 for high level, 2 for rising edge and 3 for falling edge.
- R8: When bit n of the edge-select register (0x1C) is 1, pin n latches an event on every change of its synchronized level and its 2-bit code is ignored.
- R9: The status register (0x18) keeps every detected event until software clears it. Writing 1 to a bit clears it, and writing 0 to a bit leaves it unchanged.
- R10: If a level condition is still true in the same cycle as a write-1-to-clear, the status bit stays 1.
- R11: Status bits latch whether or not their mask bit (register 0x14) is set. `irq` is a register that is 1 exactly when some bit of status AND mask was 1 in the previous cycle.
- R12: Reset clears the data, direction, config, mask and edge-select registers and drives `irq` low. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | PINS | Raw pad levels |
| pad_out | output | PINS | Driven output values |
| pad_oe | output | PINS | Output enable per pin |
| irq | output | 1 | Combined interrupt, registered |

## Verification
The bench builds the port with its default parameters: PINS = 32 and ADDR_W = 8. With these values both configuration registers are full, so the table of trigger vectors can reach pins in each half, including pins 15, 16 and 31 at the boundaries of the code fields. Each vector gives a pin, a code, an edge-select bit and a level transition. The vectors cover each condition both firing and not firing, and include an edge-select case that overrides a level code.

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int PINS   = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_PAD  = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_CFGA = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_CFGB = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] A_BOTH = ADDR_W'('h1C);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'('h84);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'('h88);
  localparam logic [ADDR_W-1:0] A_TGL  = ADDR_W'('h8C);

  logic [PINS-1:0] out_q, dir_q, mask_q, stat_q, both_q;
  logic [31:0]     cfga_q, cfgb_q;
  logic [PINS-1:0] sync_a, sync_b, sync_c;
  logic [PINS-1:0] hit;
  logic            irq_q;
  logic [PINS-1:0] wmask;

  assign wmask   = bus_wdata[PINS-1:0];
  assign pad_out = out_q;
  assign pad_oe  = dir_q;
  assign irq     = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
      sync_c <= '0;
    end else begin
      sync_a <= pad_in;
      sync_b <= sync_a;
      sync_c <= sync_b;
    end
  end

  for (genvar n = 0; n < PINS; n++) begin : g_det
    logic [1:0] code;
    logic       rise, fall;
    assign code = (n < 16) ? cfga_q[(n % 16) * 2 +: 2] : cfgb_q[(n % 16) * 2 +: 2];
    assign rise = sync_b[n] & ~sync_c[n];
    assign fall = ~sync_b[n] & sync_c[n];
    always_comb begin
      if (both_q[n]) hit[n] = rise | fall;
      else begin
        case (code)
          2'd0:    hit[n] = ~sync_b[n];
          2'd1:    hit[n] = sync_b[n];
          2'd2:    hit[n] = rise;
          default: hit[n] = fall;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      cfga_q <= '0;
      cfgb_q <= '0;
      mask_q <= '0;
      both_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_DATA:  out_q  <= wmask;
        A_DIR:   dir_q  <= wmask;
        A_CFGA:  cfga_q <= bus_wdata;
        A_CFGB:  cfgb_q <= bus_wdata;
        A_MASK:  mask_q <= wmask;
        A_BOTH:  both_q <= wmask;
        A_SET:   out_q  <= out_q | wmask;
        A_CLR:   out_q  <= out_q & ~wmask;
        A_TGL:   out_q  <= out_q ^ wmask;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= ((bus_wr && bus_addr == A_STAT) ? (stat_q & ~wmask) : stat_q) | hit;
      irq_q  <= |(stat_q & mask_q);
    end
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = 32'(out_q);
      A_DIR:   bus_rdata = 32'(dir_q);
      A_PAD:   bus_rdata = 32'(sync_b);
      A_CFGA:  bus_rdata = cfga_q;
      A_CFGB:  bus_rdata = cfgb_q;
      A_MASK:  bus_rdata = 32'(mask_q);
      A_STAT:  bus_rdata = 32'(stat_q);
      A_BOTH:  bus_rdata = 32'(both_q);
      default: bus_rdata = '0;
    endcase
  end

  // R3: masked bits end high, others keep their value
  a_r3_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_SET) |=>
      ((out_q & $past(wmask)) == $past(wmask)) &&
      ((out_q & ~$past(wmask)) == ($past(out_q) & ~$past(wmask))));

  a_r4_clear_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CLR) |=>
      ((out_q & $past(wmask)) == '0) &&
      ((out_q & ~$past(wmask)) == ($past(out_q) & ~$past(wmask))));

  a_r5_toggle_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_TGL) |=> ((out_q ^ $past(out_q)) == $past(wmask)));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == A_STAT) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  a_r11_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mask_q) == '0) |-> !irq_q);

  a_r1_oe_follows_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DIR) |=> (pad_oe == $past(wmask)));
endmodule

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PINS = 32;
  localparam int NVEC = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_port #(.PINS(PINS), .ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

  // {pin, code, edge_sel, start level, end level, expected status bit}
  typedef struct packed {
    logic [4:0] pin;
    logic [1:0] code;
    logic       both;
    logic       lv0;
    logic       lv1;
    logic       exp;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{5'd3,  2'd0, 1'b0, 1'b1, 1'b0, 1'b1},
    '{5'd15, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{5'd16, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1},
    '{5'd7,  2'd1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{5'd31, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1},
    '{5'd0,  2'd2, 1'b0, 1'b1, 1'b0, 1'b0},
    '{5'd20, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1},
    '{5'd9,  2'd3, 1'b0, 1'b0, 1'b1, 1'b0},
    '{5'd12, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1},
    '{5'd25, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1},
    '{5'd18, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0},
    '{5'd1,  2'd0, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; #1;
    d = bus_rdata;
  endtask

  task automatic clocks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    clocks(3);
    #2 rst_n = 1'b1;
    // R12 reset values and unmapped offsets
    rd(8'h00, v); check("R12 data", v, 0);
    rd(8'h04, v); check("R12 dir", v, 0);
    rd(8'h0C, v); check("R12 cfgA", v, 0);
    rd(8'h10, v); check("R12 cfgB", v, 0);
    rd(8'h14, v); check("R12 mask", v, 0);
    rd(8'h1C, v); check("R12 edge", v, 0);
    check("R12 irq", {31'd0, irq}, 0);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h20, v); check("R12 unmapped", v, 0);
    wr(8'h04, 32'h0);

    // R1 direction
    wr(8'h04, 32'hA5A5_0F0F);
    check("R1 pad_oe", pad_oe, 32'hA5A5_0F0F);
    rd(8'h04, v); check("R1 dir read", v, 32'hA5A5_0F0F);

    // R2 data
    wr(8'h00, 32'h1234_5678);
    rd(8'h00, v); check("R2 data read", v, 32'h1234_5678);
    check("R2 pad_out", pad_out, 32'h1234_5678);

    // R3 R4 R5 aliases
    wr(8'h84, 32'h0000_FF00);
    rd(8'h00, v); check("R3 set", v, 32'h1234_FF78);
    rd(8'h84, v); check("R3 alias reads zero", v, 0);
    wr(8'h88, 32'h1200_0F08);
    rd(8'h00, v); check("R4 clear", v, 32'h0034_F070);
    rd(8'h88, v); check("R4 alias reads zero", v, 0);
    wr(8'h8C, 32'hFFFF_0000);
    rd(8'h00, v); check("R5 toggle", v, 32'hFFCB_F070);
    rd(8'h8C, v); check("R5 alias reads zero", v, 0);

    // R6 synchronizer latency
    @(negedge clk); pad_in = 32'hC0DE_0001;
    @(posedge clk); #1; bus_addr = 8'h08; #1;
    check("R6 not after one edge", bus_rdata, 32'h0);
    @(posedge clk); #1;
    check("R6 after two edges", bus_rdata, 32'hC0DE_0001);

    // R7 R8 trigger table
    for (int i = 0; i < NVEC; i++) begin
      vec_t t = VECS[i];
      logic [31:0] bit_m = 32'd1 << t.pin;
      logic [31:0] cfg = 32'(t.code) << ((t.pin % 16) * 2);
      @(negedge clk); pad_in = t.lv0 ? bit_m : 32'h0;
      clocks(4);
      wr(8'h0C, t.pin < 16 ? cfg : 32'h0);
      wr(8'h10, t.pin < 16 ? 32'h0 : cfg);
      wr(8'h1C, t.both ? bit_m : 32'h0);
      clocks(1);
      wr(8'h18, 32'hFFFF_FFFF);
      @(negedge clk); pad_in = t.lv1 ? bit_m : 32'h0;
      clocks(4);
      rd(8'h18, v);
      check(t.both ? $sformatf("R8 vec%0d pin%0d", i, t.pin) : $sformatf("R7 vec%0d pin%0d", i, t.pin),
            {31'd0, v[t.pin]}, {31'd0, t.exp});
    end

    // R9 sticky, write-0 no effect, write-1 clears (pin 4 rising)
    wr(8'h1C, 32'h0);
    wr(8'h0C, 32'hAAAA_AAAA);
    wr(8'h10, 32'hAAAA_AAAA);
    @(negedge clk); pad_in = 32'h0;
    clocks(4);
    wr(8'h18, 32'hFFFF_FFFF);
    @(negedge clk); pad_in = 32'h10;
    clocks(4);
    @(negedge clk); pad_in = 32'h0;
    clocks(4);
    rd(8'h18, v); check("R9 sticky after pulse", v, 32'h10);
    wr(8'h18, 32'hFFFF_FFEF);
    rd(8'h18, v); check("R9 write zero keeps", v, 32'h10);
    wr(8'h18, 32'h10);
    rd(8'h18, v); check("R9 write one clears", v, 0);

    // R10 level re-asserts through clear (pin 2 high level)
    wr(8'h0C, 32'hAAAA_AA9A);
    @(negedge clk); pad_in = 32'h4;
    clocks(4);
    wr(8'h18, 32'h4);
    rd(8'h18, v); check("R10 level stays set", v & 32'h4, 32'h4);
    wr(8'h0C, 32'hAAAA_AAAA);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, v); check("R10 cleared once rising", v, 0);

    // R11 mask and irq (pin 6 rising)
    @(negedge clk); pad_in = 32'h44;
    clocks(4);
    rd(8'h18, v); check("R11 status latches unmasked", v, 32'h40);
    check("R11 irq low when masked", {31'd0, irq}, 0);
    wr(8'h14, 32'h40);
    check("R11 irq not yet", {31'd0, irq}, 0);
    clocks(1);
    check("R11 irq asserted", {31'd0, irq}, 1);
    wr(8'h18, 32'h40);
    clocks(1);
    check("R11 irq drops after clear", {31'd0, irq}, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule